// File: doc/BRIEF.md
# Three-wire serial register slave

This block answers a host on a three-wire control port: a serial clock, a data line and an active-low enable. The host is always the master. A frame starts when the enable falls. Its first nine bits form a header: a device code, a direction flag and a register number. Sixteen data bits follow. Write frames update one of four configuration words, and the slave shows those words on a parallel output for neighbouring logic. Read frames return a received-signal-strength status word, one half of a fixed 32-bit identifier, or zero for a configuration word.

All three port lines are sampled by the block's own system clock, and the block finds the serial clock edges in that domain. The serial data output and its drive enable come straight from flip-flops. A pad outside the block merges the two directions onto one wire. The receiver measures signal strength elsewhere and delivers it as a 7-bit input.

Top module: `ctl3w_slave`

## Requirements
- R1: A frame is taken most significant bit first, as follows: device code (3 bits), direction flag (1 bit, 1 = read, 0 = write), register number (5 bits), data (16 bits). The slave samples each bit on a rising edge of the serial clock.
- R2: The slave responds only when the device code is binary 101. For any other code, no register changes and the drive enable stays low.
- R3: A write frame commits on the first falling serial-clock edge after the enable goes high. It commits only if exactly 25 bits arrived.
- R4: In a read frame, the rising edge that follows the register number starts the data phase, after the half-cycle turnaround. From that edge the slave drives data bits 15 down to 0, one bit per rising edge, and holds the drive enable high.
- R5: After the enable goes high, the slave keeps driving until the next falling serial-clock edge, then releases the line.
- R6: Registers 4 to 7 are write-only configuration words. They appear on `cfg_q` with register 4 at bits 15:0, register 5 at 31:16, register 6 at 47:32 and register 7 at 63:48.
- R7: Register 3 is read-only. It returns `rssi_in` in bits 6:0 and zeros above. The code 0 stands for 0 dBm and the code 127 for -127 dBm.
- R8: Registers 30 and 31 are read-only. Register 30 returns bits 15:0 of the identifier 0x10B9825D, which is 0x825D. Register 31 returns bits 31:16, which is 0x10B9.
- R9: A read of registers 4 to 7 returns zero with the line driven. A read of a register number that is not implemented leaves the line released. A write to a read-only or unimplemented register changes nothing.
- R10: If the enable rises before all 25 bits have arrived, the frame is dropped and no register changes.
- R11: Reset clears all configuration words to zero and releases the data line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples the serial port |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial clock from the host |
| ser_en_n | input | 1 | Active-low frame enable from the host |
| ser_din | input | 1 | Serial data from the host |
| rssi_in | input | 7 | Signal-strength code returned by register 3 |
| ser_dout | output | 1 | Serial read data toward the pad |
| ser_dout_en | output | 1 | Pad drive enable for read data |
| cfg_q | output | 64 | Configuration words for registers 4 to 7 |

## Verification
The bench goes after frames cut short by an early enable rise. A design that counted loosely would commit a half-shifted word there. It sends writes to a foreign device code and to read-only registers, where a decoder that ignored the code or the register number would corrupt a configuration word. For reads, it checks that bit 15 appears on the edge right after the register number. An off-by-one design returns a shifted word. It also checks that the drive enable stays up after the enable rises and drops only on the following falling clock edge. Releasing too early or never releasing shows up in the drive-enable samples. Reads of unimplemented registers must leave the line released.

// File: rtl/ctl3w_pkg.sv
`timescale 1ns/1ps
package ctl3w_pkg;
  localparam int          DEV_W       = 3;
  localparam int          REG_AW      = 5;
  localparam int          WORD_W      = 16;
  localparam logic [2:0]  DEV_CODE    = 3'b101;
  localparam int          RSSI_BITS   = 7;
  localparam int          RSSI_REG    = 3;
  localparam int          CFG_FIRST   = 4;
  localparam int          CFG_COUNT   = 4;
  localparam int          IDLO_REG    = 30;
  localparam int          IDHI_REG    = 31;
  localparam logic [31:0] ID_WORD     = 32'h10B9825D;
  localparam int          SYNC_DEPTH  = 2;
endpackage

// File: rtl/ctl3w_sync.sv
`timescale 1ns/1ps
module ctl3w_sync #(
  parameter int          W       = 3,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/ctl3w_frame.sv
`timescale 1ns/1ps
module ctl3w_frame #(
  parameter int         DW     = 16,
  parameter int         AW     = 5,
  parameter int         DEVW   = 3,
  parameter logic [DEVW-1:0] DEV_ID = 3'b101
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sclk_rise,
  input  logic          sclk_fall,
  input  logic          sen_q,
  input  logic          sen_rise,
  input  logic          sdi_q,
  input  logic [DW-1:0] rd_data,
  input  logic          rd_impl,
  output logic [AW-1:0] hdr_addr,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          sdo,
  output logic          sdo_oe
);
  localparam int HDR_W      = DEVW + 1 + AW;
  localparam int FRAME_BITS = HDR_W + DW;
  localparam int CNT_W      = $clog2(FRAME_BITS + 2);
  localparam logic [CNT_W-1:0] C_HDR  = CNT_W'(HDR_W);
  localparam logic [CNT_W-1:0] C_FULL = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] C_OVER = CNT_W'(FRAME_BITS + 1);

  logic [CNT_W-1:0] cnt;
  logic [HDR_W-1:0] hdr;
  logic [DW-1:0]    dsr;
  logic             rd_mode;
  logic             arm;

  wire dev_ok = (hdr[HDR_W-1 -: DEVW] == DEV_ID);
  wire is_rd  = hdr[AW];
  assign hdr_addr = hdr[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      hdr     <= '0;
      dsr     <= '0;
      rd_mode <= 1'b0;
      arm     <= 1'b0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      sdo     <= 1'b0;
      sdo_oe  <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (sen_q) begin
        cnt     <= '0;
        rd_mode <= 1'b0;
        if (sen_rise) begin
          arm <= (cnt == C_FULL) && dev_ok && !is_rd;
        end else if (sclk_fall) begin
          wr_en   <= arm;
          wr_addr <= hdr[AW-1:0];
          wr_data <= dsr;
          arm     <= 1'b0;
          sdo     <= 1'b0;
          sdo_oe  <= 1'b0;
        end
      end else if (sclk_rise) begin
        if (cnt != C_OVER) cnt <= cnt + 1'b1;
        if (cnt < C_HDR) begin
          hdr <= {hdr[HDR_W-2:0], sdi_q};
        end else if (cnt < C_FULL) begin
          if (cnt == C_HDR && is_rd) begin
            if (dev_ok && rd_impl) begin
              sdo_oe  <= 1'b1;
              sdo     <= rd_data[DW-1];
              dsr     <= {rd_data[DW-2:0], 1'b0};
              rd_mode <= 1'b1;
            end
          end else if (rd_mode) begin
            sdo <= dsr[DW-1];
            dsr <= {dsr[DW-2:0], 1'b0};
          end else if (!is_rd) begin
            dsr <= {dsr[DW-2:0], sdi_q};
          end
        end
      end
    end
  end

  AST_COMMIT_AFTER_EN: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(sen_q)); // R3
  AST_OE_STARTS_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    $rose(sdo_oe) |-> !$past(sen_q)); // R4
  AST_OE_ENDS_AFTER_EN: assert property (@(posedge clk) disable iff (rst)
    $fell(sdo_oe) |-> $past(sen_q) && $past(sclk_fall)); // R5
endmodule

// File: rtl/ctl3w_regbank.sv
`timescale 1ns/1ps
module ctl3w_regbank #(
  parameter int          DW        = 16,
  parameter int          AW        = 5,
  parameter int          RSSI_W    = 7,
  parameter int          RSSI_A    = 3,
  parameter int          CFG_BASE  = 4,
  parameter int          CFG_NUM   = 4,
  parameter int          IDLO_A    = 30,
  parameter int          IDHI_A    = 31,
  parameter logic [2*DW-1:0] ID_CODE = 32'h10B9825D
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [AW-1:0]         wr_addr,
  input  logic [DW-1:0]         wr_data,
  input  logic [RSSI_W-1:0]     rssi,
  input  logic [AW-1:0]         rd_addr,
  output logic [DW-1:0]         rd_data,
  output logic                  rd_impl,
  output logic [CFG_NUM*DW-1:0] cfg_q
);
  localparam logic [AW:0]   CFG_LO = (AW+1)'(CFG_BASE);
  localparam logic [AW:0]   CFG_HI = (AW+1)'(CFG_BASE + CFG_NUM);
  localparam logic [AW-1:0] A_RSSI = AW'(RSSI_A);
  localparam logic [AW-1:0] A_IDLO = AW'(IDLO_A);
  localparam logic [AW-1:0] A_IDHI = AW'(IDHI_A);

  wire wr_in_cfg = ({1'b0, wr_addr} >= CFG_LO) && ({1'b0, wr_addr} < CFG_HI);
  wire rd_in_cfg = ({1'b0, rd_addr} >= CFG_LO) && ({1'b0, rd_addr} < CFG_HI);

  for (genvar g = 0; g < CFG_NUM; g++) begin : g_cfg
    localparam logic [AW-1:0] MY_A = AW'(CFG_BASE + g);
    logic [DW-1:0] r;
    always_ff @(posedge clk) begin
      if (rst)                          r <= '0;
      else if (wr_en && wr_addr == MY_A) r <= wr_data;
    end
    assign cfg_q[g*DW +: DW] = r;
  end

  always_comb begin
    rd_data = '0;
    rd_impl = 1'b0;
    if (rd_addr == A_RSSI) begin
      rd_data[RSSI_W-1:0] = rssi;
      rd_impl = 1'b1;
    end else if (rd_addr == A_IDLO) begin
      rd_data = ID_CODE[DW-1:0];
      rd_impl = 1'b1;
    end else if (rd_addr == A_IDHI) begin
      rd_data = ID_CODE[2*DW-1:DW];
      rd_impl = 1'b1;
    end else if (rd_in_cfg) begin
      rd_impl = 1'b1;
    end
  end

  AST_CFG_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(cfg_q)); // R10
  AST_CFG_HOLD_FOREIGN: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_in_cfg) |=> $stable(cfg_q)); // R9
  AST_CFG_ONE_WORD: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> ($countones(cfg_q ^ $past(cfg_q)) <= DW)); // R6
endmodule

// File: rtl/ctl3w_slave.sv
`timescale 1ns/1ps
module ctl3w_slave
  import ctl3w_pkg::*;
#(
  parameter int DW       = WORD_W,
  parameter int AW       = REG_AW,
  parameter int RSSI_W   = RSSI_BITS,
  parameter int CFG_NUM  = CFG_COUNT,
  parameter int STAGES   = SYNC_DEPTH
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ser_clk,
  input  logic                  ser_en_n,
  input  logic                  ser_din,
  input  logic [RSSI_W-1:0]     rssi_in,
  output logic                  ser_dout,
  output logic                  ser_dout_en,
  output logic [CFG_NUM*DW-1:0] cfg_q
);
  logic [2:0]    pins_q;
  logic          sclk_d, sen_d;
  logic [AW-1:0] hdr_addr, wr_addr;
  logic [DW-1:0] rd_data, wr_data;
  logic          rd_impl, wr_en;

  ctl3w_sync #(.W(3), .STAGES(STAGES), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst(rst), .d({ser_clk, ser_en_n, ser_din}), .q(pins_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d <= 1'b0;
      sen_d  <= 1'b1;
    end else begin
      sclk_d <= pins_q[2];
      sen_d  <= pins_q[1];
    end
  end

  wire sclk_rise = pins_q[2] & ~sclk_d;
  wire sclk_fall = ~pins_q[2] & sclk_d;
  wire sen_rise  = pins_q[1] & ~sen_d;

  ctl3w_frame #(.DW(DW), .AW(AW), .DEVW(DEV_W), .DEV_ID(DEV_CODE)) u_frame (
    .clk(clk), .rst(rst),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .sen_q(pins_q[1]), .sen_rise(sen_rise), .sdi_q(pins_q[0]),
    .rd_data(rd_data), .rd_impl(rd_impl), .hdr_addr(hdr_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sdo(ser_dout), .sdo_oe(ser_dout_en)
  );

  ctl3w_regbank #(
    .DW(DW), .AW(AW), .RSSI_W(RSSI_W), .RSSI_A(RSSI_REG),
    .CFG_BASE(CFG_FIRST), .CFG_NUM(CFG_NUM),
    .IDLO_A(IDLO_REG), .IDHI_A(IDHI_REG), .ID_CODE(ID_WORD)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rssi(rssi_in), .rd_addr(hdr_addr), .rd_data(rd_data), .rd_impl(rd_impl),
    .cfg_q(cfg_q)
  );

  AST_RESET_RELEASED: assert property (@(posedge clk)
    $past(rst) |-> !ser_dout_en && cfg_q == '0); // R11
endmodule

// File: tb/ctl3w_slave_bench.sv
`timescale 1ns/1ps
module ctl3w_slave_bench;
  localparam int HP = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ser_clk = 1'b0;
  logic        ser_en_n = 1'b1;
  logic        ser_din = 1'b0;
  logic [6:0]  rssi_in = 7'h00;
  logic        ser_dout, ser_dout_en;
  logic [63:0] cfg_q;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [15:0] model [4];

  always #2.5 clk = ~clk;

  ctl3w_slave u_ctl3w_slave (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_en_n(ser_en_n),
    .ser_din(ser_din), .rssi_in(rssi_in), .ser_dout(ser_dout),
    .ser_dout_en(ser_dout_en), .cfg_q(cfg_q)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit impl(input logic [4:0] ra);
    return ra == 5'd3 || (ra >= 5'd4 && ra <= 5'd7) || ra == 5'd30 || ra == 5'd31;
  endfunction

  function automatic logic [15:0] exp_read(input logic [4:0] ra, input logic [6:0] rs);
    if (ra == 5'd3)  return {9'd0, rs};
    if (ra == 5'd30) return 16'h825D;
    if (ra == 5'd31) return 16'h10B9;
    return 16'h0000;
  endfunction

  function automatic logic [63:0] packed_model();
    return {model[3], model[2], model[1], model[0]};
  endfunction

  task automatic run_frame(input logic [2:0] dev, input logic rw, input logic [4:0] ra,
                           input logic [15:0] wd, input int nb,
                           output logic [15:0] rd, output int oe_cnt, output logic oe_hold);
    logic [24:0] f;
    f = {dev, rw, ra, wd};
    rd = '0;
    oe_cnt = 0;
    ser_en_n = 1'b0;
    tick(HP);
    for (int i = 0; i < nb; i++) begin
      ser_din = (i < 9 || !rw) ? f[24-i] : 1'b0;
      tick(HP);
      ser_clk = 1'b1;
      tick(HP);
      if (i >= 9) begin
        rd = {rd[14:0], ser_dout};
        if (ser_dout_en) oe_cnt++;
      end
      ser_clk = 1'b0;
    end
    tick(HP);
    ser_en_n = 1'b1;
    tick(HP);
    oe_hold = ser_dout_en;
    ser_clk = 1'b1;
    tick(HP);
    ser_clk = 1'b0;
    tick(HP);
    if (dev == 3'b101 && !rw && nb == 25 && ra >= 5'd4 && ra <= 5'd7)
      model[ra-5'd4] = wd;
  endtask

  task automatic do_frame(input string req, input logic [2:0] dev, input logic rw,
                          input logic [4:0] ra, input logic [15:0] wd, input int nb);
    logic [15:0] rd;
    int          oe_cnt;
    logic        oe_hold;
    bit          hit;
    run_frame(dev, rw, ra, wd, nb, rd, oe_cnt, oe_hold);
    hit = (dev == 3'b101) && impl(ra);
    chk({req, " cfg"}, cfg_q, packed_model());
    chk("R5 released", {63'd0, ser_dout_en}, 64'd0);
    if (rw && nb == 25) begin
      if (hit) begin
        chk({req, " R4 data"}, {48'd0, rd}, {48'd0, exp_read(ra, rssi_in)});
        chk("R4 drive bits", oe_cnt, 16);
        chk("R5 hold", {63'd0, oe_hold}, 64'd1);
      end else begin
        chk({req, " R2 R9 no drive"}, oe_cnt, 0);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R3 watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    logic [4:0] picks [8];
    seed = $urandom(32'd20250);
    picks = '{5'd3, 5'd4, 5'd5, 5'd6, 5'd7, 5'd30, 5'd31, 5'd12};
    for (int k = 0; k < 4; k++) model[k] = '0;
    tick(5);
    rst = 1'b0;
    tick(2);
    chk("R11 reset cfg", cfg_q, 64'd0);
    chk("R11 reset oe", {63'd0, ser_dout_en}, 64'd0);

    do_frame("R1 R3 R6 write reg5", 3'b101, 1'b0, 5'd5, 16'h8001, 25);
    chk("R6 reg5 lane", {48'd0, cfg_q[31:16]}, 64'h8001);
    do_frame("R6 write reg4", 3'b101, 1'b0, 5'd4, 16'hA5C3, 25);
    do_frame("R6 write reg7", 3'b101, 1'b0, 5'd7, 16'h1234, 25);
    chk("R6 reg7 lane", {48'd0, cfg_q[63:48]}, 64'h1234);
    rssi_in = 7'h35;
    do_frame("R7 read rssi", 3'b101, 1'b1, 5'd3, 16'h0, 25);
    rssi_in = 7'h7F;
    do_frame("R7 read rssi max", 3'b101, 1'b1, 5'd3, 16'h0, 25);
    do_frame("R8 read id low", 3'b101, 1'b1, 5'd30, 16'h0, 25);
    do_frame("R8 read id high", 3'b101, 1'b1, 5'd31, 16'h0, 25);
    do_frame("R9 read write-only", 3'b101, 1'b1, 5'd5, 16'h0, 25);
    do_frame("R9 read unimpl", 3'b101, 1'b1, 5'd12, 16'h0, 25);
    do_frame("R9 write read-only", 3'b101, 1'b0, 5'd3, 16'hFFFF, 25);
    do_frame("R2 foreign write", 3'b100, 1'b0, 5'd6, 16'hBEEF, 25);
    do_frame("R2 foreign read", 3'b001, 1'b1, 5'd30, 16'h0, 25);
    do_frame("R10 abort write", 3'b101, 1'b0, 5'd6, 16'hDEAD, 20);
    chk("R10 reg6 untouched", {48'd0, cfg_q[47:32]}, 64'd0);

    for (int n = 0; n < 70; n++) begin
      logic [2:0]  dv;
      logic [4:0]  ra;
      int          nb;
      dv = ($urandom % 4 == 0) ? 3'($urandom) : 3'b101;
      ra = ($urandom % 8 == 7) ? 5'($urandom) : picks[$urandom % 7];
      nb = ($urandom % 5 == 0) ? 1 + int'($urandom % 24) : 25;
      rssi_in = 7'($urandom);
      do_frame("R3 R10 random", dv, 1'($urandom), ra, 16'($urandom), nb);
    end

    rst = 1'b1;
    tick(2);
    rst = 1'b0;
    tick(1);
    for (int k = 0; k < 4; k++) model[k] = '0;
    chk("R11 mid-run reset", cfg_q, 64'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule